// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

The block is a register-mapped general purpose I/O controller for up to six banks of 32 pins. Software drives outputs through write-one set and clear ports, chooses per pin whether the pad is driven, reads back the synchronized pad levels, and arms rising and falling edge capture per pin. Captured edges collect in a sticky per-bank status word that software clears by writing ones. A single interrupt line is raised while any captured edge is pending in any bank.

Banks 0 to 2 sit in a first address window and banks 3 to 5 repeat the same layout in a second window starting at 0x100. The total pin count is a parameter, so the last bank can be partly populated. A parameterized range of pins uses the opposite direction polarity. Pad inputs are brought into the clock domain through a two-stage synchronizer before level reads and edge capture.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: Byte offsets of the register groups are level 0x00, direction 0x0C, set 0x18, clear 0x24, rising enable 0x30, falling enable 0x3C, status 0x48 and edge mask 0x9C; bank n adds 4*n for n below 3 and 0x100 + 4*(n-3) for n from 3 to 5. Direction, rising enable, falling enable and mask read back what was written.
- R2: Writing a 1 to a bit at the set address drives that pin_out bit high on the next clock edge, a 1 at the clear address drives it low, and 0 bits leave it unchanged; both addresses read back the output latch, which resets to 0.
- R3: The level register returns pin_in through a two-flop synchronizer: a change made before a clock edge is visible on a read after the second following edge, whatever the pin direction.
- R4: pin_oe is 1 when a pin is driven. A direction bit of 1 drives the pin, except for pins INV_LO to INV_HI (default 86 to 89) where 0 drives it. After reset every pin is undriven, so the direction bits of that range reset to 1 and all others to 0.
- R5: A status bit is set on the third clock edge after its pin rises with rising enable set, or falls with falling enable set; with both set either edge sets it.
- R6: Writing 1 to a status bit clears it, writing 0 leaves it, writing all ones clears the bank; status bits stay set with no write.
- R7: An edge is recorded only while its mask bit is 1; masks reset to 1 for implemented pins.
- R8: Bits for pins at or above NUM_PINS read as 0 and ignore writes; addresses that select no register or a bank beyond the last read as 0 and ignore writes.
- R9: When an edge event and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R10: irq is 1 exactly while some status bit of some bank is 1.
- R11: After reset pin_out, all status bits, the enables and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, committed on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | NUM_PINS | Pad input levels, asynchronous |
| pin_out | output | NUM_PINS | Output latch values |
| pin_oe | output | NUM_PINS | Pad drive enables, 1 = driven |
| irq | output | 1 | Pending edge interrupt |

## Verification
The bench goes after the second address window, where a decoder that ignored the window bit would alias bank 3 onto bank 0, and after the partly populated last bank, where missing masking would show phantom bits on read. It times a falling edge to land in the very cycle of a clearing write, which a clear-priority status update would lose. It checks the inverted-polarity range at reset, where a plain reset would leave four pins driven, and a masked edge, which a mask applied only at read would later expose in status.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  localparam int LANE_W      = 32;
  localparam int WIN_BANKS   = 3;
  localparam int NUM_KINDS   = 8;

  typedef enum logic [2:0] {
    RK_LEVEL = 3'd0,
    RK_DIR   = 3'd1,
    RK_SET   = 3'd2,
    RK_CLR   = 3'd3,
    RK_RISE  = 3'd4,
    RK_FALL  = 3'd5,
    RK_STAT  = 3'd6,
    RK_MASK  = 3'd7
  } reg_kind_e;

  // Offset of bank 0 of each register group inside a window.
  function automatic logic [7:0] kind_base(input reg_kind_e k);
    case (k)
      RK_LEVEL: kind_base = 8'h00;
      RK_DIR:   kind_base = 8'h0C;
      RK_SET:   kind_base = 8'h18;
      RK_CLR:   kind_base = 8'h24;
      RK_RISE:  kind_base = 8'h30;
      RK_FALL:  kind_base = 8'h3C;
      RK_STAT:  kind_base = 8'h48;
      default:  kind_base = 8'h9C;
    endcase
  endfunction

  // Bits of bank `bank` that map onto real pins.
  function automatic logic [LANE_W-1:0] lane_present(input int bank, input int npins);
    for (int i = 0; i < LANE_W; i++)
      lane_present[i] = ((bank * LANE_W + i) < npins);
  endfunction

  // Bits of bank `bank` whose direction polarity is swapped.
  function automatic logic [LANE_W-1:0] lane_swapped(input int bank, input int lo, input int hi);
    for (int i = 0; i < LANE_W; i++)
      lane_swapped[i] = ((bank * LANE_W + i) >= lo) && ((bank * LANE_W + i) <= hi);
  endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_edge_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int NUM_BANKS = 4,
  localparam int BIDX_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output reg_kind_e         kind,
  output logic [BIDX_W-1:0] bank
);

  logic [7:0] low;
  logic       second_win;
  logic       upper_clear;

  assign low         = addr[7:0];
  assign second_win  = addr[8];
  assign upper_clear = ((addr >> 9) == '0);

  always_comb begin
    hit  = 1'b0;
    kind = RK_LEVEL;
    bank = '0;
    for (int k = 0; k < NUM_KINDS; k++) begin
      for (int j = 0; j < WIN_BANKS; j++) begin
        if (upper_clear &&
            (low == kind_base(reg_kind_e'(k)) + 8'(4 * j)) &&
            ((int'(second_win) * WIN_BANKS + j) < NUM_BANKS)) begin
          hit  = 1'b1;
          kind = reg_kind_e'(k);
          bank = BIDX_W'(int'(second_win) * WIN_BANKS + j);
        end
      end
    end
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad,
  output logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] prev
);

  logic [WIDTH-1:0] meta_q, sync_q, hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      hist_q <= '0;
    end else begin
      meta_q <= pad;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign cur  = sync_q;
  assign prev = hist_q;

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_edge_pkg::*;
#(
  parameter int BANK_ID  = 0,
  parameter int NUM_PINS = 120,
  parameter int INV_LO   = 86,
  parameter int INV_HI   = 89,
  localparam logic [LANE_W-1:0] PRESENT = lane_present(BANK_ID, NUM_PINS),
  localparam logic [LANE_W-1:0] SWAPPED = lane_swapped(BANK_ID, INV_LO, INV_HI) & PRESENT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_kind_e         wr_kind,
  input  logic [LANE_W-1:0] wdata,
  input  logic [LANE_W-1:0] cur,
  input  logic [LANE_W-1:0] prev,
  output logic [LANE_W-1:0] dir_q,
  output logic [LANE_W-1:0] out_q,
  output logic [LANE_W-1:0] rise_q,
  output logic [LANE_W-1:0] fall_q,
  output logic [LANE_W-1:0] stat_q,
  output logic [LANE_W-1:0] mask_q
);

  logic              dir_en, out_en, rise_en, fall_en, mask_en;
  logic [LANE_W-1:0] dir_d, out_d, rise_d, fall_d, stat_d, mask_d;
  logic [LANE_W-1:0] wvalid, evt, clr_bits;

  assign wvalid = wdata & PRESENT;

  // Next-state logic
  always_comb begin
    dir_en  = wr_en && (wr_kind == RK_DIR);
    rise_en = wr_en && (wr_kind == RK_RISE);
    fall_en = wr_en && (wr_kind == RK_FALL);
    mask_en = wr_en && (wr_kind == RK_MASK);
    out_en  = wr_en && ((wr_kind == RK_SET) || (wr_kind == RK_CLR));

    dir_d  = wvalid;
    rise_d = wvalid;
    fall_d = wvalid;
    mask_d = wvalid;
    out_d  = (wr_kind == RK_SET) ? (out_q | wvalid) : (out_q & ~wvalid);

    evt = ((cur & ~prev & rise_q) | (~cur & prev & fall_q)) & mask_q & PRESENT;
    clr_bits = (wr_en && (wr_kind == RK_STAT)) ? wdata : '0;
    // A fresh event outranks a clear in the same cycle.
    stat_d = (stat_q & ~clr_bits) | evt;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= SWAPPED;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      stat_q <= '0;
      mask_q <= PRESENT;
    end else begin
      if (dir_en)  dir_q  <= dir_d;
      if (out_en)  out_q  <= out_d;
      if (rise_en) rise_q <= rise_d;
      if (fall_en) fall_q <= fall_d;
      if (mask_en) mask_q <= mask_d;
      stat_q <= stat_d;
    end
  end

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int NUM_PINS = 120,
  parameter int INV_LO   = 86,
  parameter int INV_HI   = 89
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [LANE_W-1:0]   bus_wdata,
  output logic [LANE_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);

  localparam int NUM_BANKS = (NUM_PINS + LANE_W - 1) / LANE_W;
  localparam int FLAT_W    = NUM_BANKS * LANE_W;
  localparam int BIDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic [NUM_PINS-1:0] cur_s, prev_s;
  logic [FLAT_W-1:0]   cur_pad, prev_pad;
  logic [FLAT_W-1:0]   dir_flat, out_flat, stat_flat, swap_flat;
  logic [LANE_W-1:0]   dir_a  [NUM_BANKS];
  logic [LANE_W-1:0]   out_a  [NUM_BANKS];
  logic [LANE_W-1:0]   rise_a [NUM_BANKS];
  logic [LANE_W-1:0]   fall_a [NUM_BANKS];
  logic [LANE_W-1:0]   stat_a [NUM_BANKS];
  logic [LANE_W-1:0]   mask_a [NUM_BANKS];

  logic              dec_hit;
  reg_kind_e         dec_kind;
  logic [BIDX_W-1:0] dec_bank;

  gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pad  (pin_in),
    .cur  (cur_s),
    .prev (prev_s)
  );

  assign cur_pad  = FLAT_W'(cur_s);
  assign prev_pad = FLAT_W'(prev_s);

  gpio_addr_dec #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_dec (
    .addr(bus_addr),
    .hit (dec_hit),
    .kind(dec_kind),
    .bank(dec_bank)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_wr;
    assign bank_wr = bus_we && dec_hit && (dec_bank == BIDX_W'(b));

    gpio_bank #(
      .BANK_ID (b),
      .NUM_PINS(NUM_PINS),
      .INV_LO  (INV_LO),
      .INV_HI  (INV_HI)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bank_wr),
      .wr_kind(dec_kind),
      .wdata  (bus_wdata),
      .cur    (cur_pad[b*LANE_W +: LANE_W]),
      .prev   (prev_pad[b*LANE_W +: LANE_W]),
      .dir_q  (dir_a[b]),
      .out_q  (out_a[b]),
      .rise_q (rise_a[b]),
      .fall_q (fall_a[b]),
      .stat_q (stat_a[b]),
      .mask_q (mask_a[b])
    );

    assign dir_flat[b*LANE_W +: LANE_W]  = dir_a[b];
    assign out_flat[b*LANE_W +: LANE_W]  = out_a[b];
    assign stat_flat[b*LANE_W +: LANE_W] = stat_a[b];
    assign swap_flat[b*LANE_W +: LANE_W] = lane_swapped(b, INV_LO, INV_HI);
  end

  assign pin_out = out_flat[NUM_PINS-1:0];
  assign pin_oe  = dir_flat[NUM_PINS-1:0] ^ swap_flat[NUM_PINS-1:0];
  assign irq     = |stat_flat;

  always_comb begin
    bus_rdata = '0;
    if (dec_hit) begin
      case (dec_kind)
        RK_LEVEL:       bus_rdata = cur_pad[dec_bank*LANE_W +: LANE_W];
        RK_DIR:         bus_rdata = dir_a[dec_bank];
        RK_SET, RK_CLR: bus_rdata = out_a[dec_bank];
        RK_RISE:        bus_rdata = rise_a[dec_bank];
        RK_FALL:        bus_rdata = fall_a[dec_bank];
        RK_STAT:        bus_rdata = stat_a[dec_bank];
        default:        bus_rdata = mask_a[dec_bank];
      endcase
    end
  end

endmodule

// File: rtl/gpio_edge_chk.sv
module gpio_edge_chk #(
  parameter int ADDR_W   = 9,
  parameter int NUM_PINS = 120
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_we,
  input logic [31:0]         bus_wdata,
  input logic [31:0]         bus_rdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic                irq
);

  localparam int NB       = (NUM_PINS + 31) / 32;
  localparam int LAST     = NB - 1;
  localparam int TAIL     = NUM_PINS - 32 * LAST;
  localparam int LAST_LVL = (LAST < 3) ? 4 * LAST : 256 + 4 * (LAST - 3);

  // R2: set port drives high on the next edge
  p_set_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(9'h018) && bus_wdata[0]) |=> pin_out[0]);

  // R2: clear port drives low on the next edge
  p_clr_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(9'h024) && bus_wdata[0]) |=> !pin_out[0]);

  // R2: outputs only move on a write
  p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(pin_out));

  // R6: pending edges stay pending without a write
  p_irq_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && irq) |=> irq);

  // R8: a hole in the map reads zero
  p_hole_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(9'h060)) |-> (bus_rdata == 32'h0));

  if (TAIL < 32) begin : g_tail
    // R8: missing pins of the last bank read zero
    p_tail_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(LAST_LVL)) |-> ((bus_rdata >> TAIL) == 32'h0));
  end

endmodule

bind gpio_edge_ctrl gpio_edge_chk #(.ADDR_W(ADDR_W), .NUM_PINS(NUM_PINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_we   (bus_we),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .pin_out  (pin_out),
  .irq      (irq)
);

// File: tb/tb_gpio_edge_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_edge_ctrl;

  localparam int NP = 120;

  typedef struct packed {
    logic        we;
    logic [8:0]  waddr;
    logic [31:0] wdata;
    logic [8:0]  raddr;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 9'h00C, 32'hA5A5_0F0F, 9'h00C, 32'hA5A5_0F0F, 4'd1},  // R1 dir bank0
    '{1'b1, 9'h10C, 32'hFFFF_FFFF, 9'h10C, 32'h00FF_FFFF, 4'd8},  // R8 partial bank3
    '{1'b1, 9'h01C, 32'h0000_00F0, 9'h028, 32'h0000_00F0, 4'd2},  // R2 latch readback
    '{1'b1, 9'h038, 32'h1234_5678, 9'h038, 32'h1234_5678, 4'd1},  // R1 rise bank2
    '{1'b1, 9'h13C, 32'h8765_4321, 9'h13C, 32'h0065_4321, 4'd8},  // R8 fall bank3
    '{1'b1, 9'h060, 32'hFFFF_FFFF, 9'h060, 32'h0000_0000, 4'd8},  // R8 hole
    '{1'b1, 9'h0A0, 32'h0F0F_0F0F, 9'h0A0, 32'h0F0F_0F0F, 4'd7},  // R7 mask bank1
    '{1'b0, 9'h000, 32'h0000_0000, 9'h014, 32'h03C0_0000, 4'd4},  // R4 dir bank2 reset
    '{1'b1, 9'h110, 32'hFFFF_FFFF, 9'h110, 32'h0000_0000, 4'd8},  // R8 absent bank4
    '{1'b0, 9'h000, 32'h0000_0000, 9'h19C, 32'h00FF_FFFF, 4'd7}   // R7 mask bank3 reset
  };

  logic          clk, rst_n, bus_we, irq;
  logic [8:0]    bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic [NP-1:0] pin_in, pin_out, pin_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  gpio_edge_ctrl #(.ADDR_W(9), .NUM_PINS(NP), .INV_LO(86), .INV_HI(89)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    step();
    bus_we    = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, input string req, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, 128'(bus_rdata), 128'(exp));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R11 / R4 reset state
    check("R11 pin_out", 128'(pin_out), 128'(0));
    check("R4 pin_oe reset", 128'(pin_oe), 128'(0));
    check("R11 irq", 128'(irq), 128'(0));
    rd(9'h048, "R11 status", 32'h0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].we) wr(VECS[i].waddr, VECS[i].wdata);
      bus_addr = VECS[i].raddr;
      #1;
      n_chk++;
      if (bus_rdata !== VECS[i].exp) begin
        n_fail++;
        $display("FAIL R%0d vector %0d: actual %h expected %h", VECS[i].req, i, bus_rdata, VECS[i].exp);
      end
      @(negedge clk);
    end

    // R2 set / clear ports
    wr(9'h018, 32'h0000_00FF);
    check("R2 set", 128'(pin_out[7:0]), 128'(8'hFF));
    wr(9'h024, 32'h0000_000F);
    check("R2 clear", 128'(pin_out[7:0]), 128'(8'hF0));
    wr(9'h018, 32'h0);
    check("R2 zero write", 128'(pin_out[7:0]), 128'(8'hF0));
    check("R2 bank1 latch", 128'(pin_out[39:32]), 128'(8'hF0));

    // R4 polarity
    check("R4 bank0 oe", 128'(pin_oe[31:0]), 128'(32'hA5A5_0F0F));
    wr(9'h014, 32'h0);
    check("R4 inverted range", 128'(pin_oe[95:64]), 128'(32'h03C0_0000));

    // R3 synchronizer latency
    pin_in[5] = 1'b1;
    pin_in[0] = 1'b1;
    step();
    rd(9'h000, "R3 one edge", 32'h0);
    step();
    rd(9'h000, "R3 two edges, output pin too", 32'h0000_0021);

    // R5 edge enables
    wr(9'h030, 32'h0000_0500);
    wr(9'h03C, 32'h0000_0600);
    pin_in[10:8] = 3'b111;
    repeat (3) step();
    rd(9'h048, "R5 rising", 32'h0000_0500);
    check("R10 irq set", 128'(irq), 128'(1));
    // R6 write-one-to-clear
    wr(9'h048, 32'h0000_0100);
    rd(9'h048, "R6 partial clear", 32'h0000_0400);
    wr(9'h048, 32'hFFFF_FFFF);
    rd(9'h048, "R6 clear all", 32'h0);
    check("R10 irq clear", 128'(irq), 128'(0));
    pin_in[10:8] = 3'b000;
    repeat (3) step();
    rd(9'h048, "R5 falling", 32'h0000_0600);
    wr(9'h048, 32'hFFFF_FFFF);

    // R7 mask
    wr(9'h09C, 32'hFFFF_FEFF);
    pin_in[8] = 1'b1;
    repeat (3) step();
    rd(9'h048, "R7 masked edge", 32'h0);
    check("R7 irq quiet", 128'(irq), 128'(0));
    wr(9'h09C, 32'hFFFF_FFFF);

    // R9 event beats clear
    pin_in[10] = 1'b1;
    repeat (3) step();
    rd(9'h048, "R5 both enables", 32'h0000_0400);
    wr(9'h048, 32'hFFFF_FFFF);
    rd(9'h048, "R6 cleared", 32'h0);
    pin_in[10] = 1'b0;
    step();
    step();
    wr(9'h048, 32'h0000_0400);
    rd(9'h048, "R9 collision", 32'h0000_0400);
    wr(9'h048, 32'h0000_0400);

    // R10 second window interrupt
    wr(9'h130, 32'h0000_0001);
    pin_in[96] = 1'b1;
    repeat (3) step();
    rd(9'h148, "R10 bank3 status", 32'h0000_0001);
    check("R10 bank3 irq", 128'(irq), 128'(1));
    wr(9'h148, 32'hFFFF_FFFF);
    check("R10 irq drop", 128'(irq), 128'(0));

    finish_run();
  end

endmodule